// File: doc/BRIEF.md
# Three-Range Shunt Auto-Ranging Controller

This block is the digital controller of a current-measurement front end. It picks one of three shunt resistors by driving two PMOS range switches. The small-shunt switch carries the most current. The mid-shunt switch sits in between. With both switches open, the largest shunt measures alone.

Three comparator flags feed the block:
- the signal is too high for the present range;
- the signal is too low for the present range;
- the supply seen by the load has sagged by more than the allowed burden.

The controller acts on a threshold flag as soon as the flag reaches it through its synchronizer. After every range change it holds the new range for a programmable number of clock cycles, so the analog path can settle before the next step. The burden flag bypasses that hold. It jumps straight to the smallest shunt, even from the largest, and never passes through the middle range.

A host may take direct control of the two switches through an override input. While the override is on, the automatic logic follows the host's setting and keeps its hold-off timer at zero. The burden flag still wins over the host.

Top module: `shunt_autorange`

## Requirements
- R1: While `rst_n` is low, and after it is released, `range_code` is 2 and both gate outputs are low, until the first step.
- R2: Range codes: 0 is the largest shunt (both gates high), 1 is the mid range (`gate_mid_n` low, `gate_small_n` high), 2 is the smallest shunt (both gates low). Code 3 never appears. Outside override, the combination "small on, mid off" is never driven.
- R3: With `cmp_below` held and no hold-off pending, the range drops by one code per step, down to code 0, where it stays.
- R4: With `cmp_above` held and no hold-off pending, the range rises by one code per step, up to code 2, where it stays.
- R5: When `cmp_above` and `cmp_below` are both asserted, the range rises.
- R6: Each comparator input passes through `SYNC_STAGES` flops. A level change that comes before rising edge 1 changes the range on edge `SYNC_STAGES+1`.
- R7: The hold-off counter loads `hold_cycles` on every range change and on every cycle that sees the synchronized burden flag. While it is nonzero, threshold steps are blocked. Consecutive threshold steps are therefore `hold_cycles+1` edges apart.
- R8: The synchronized burden flag sets range 2 and drives both gates low on the next edge, whatever the hold-off count. From range 0 the range never passes through 1.
- R9: While `ovr_en` is high, on each edge:
  - the gates follow `ovr_small_on` and `ovr_mid_on`, inverted;
  - `range_code` becomes 2 if the small switch is requested, otherwise 1 if the mid switch is requested, otherwise 0;
  - the hold-off is cleared;
  - the threshold flags have no effect.
- R10: The burden flag takes priority over the override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_above | input | 1 | Asynchronous flag: signal above the turn-on threshold |
| cmp_below | input | 1 | Asynchronous flag: signal below the turn-off threshold |
| cmp_burden | input | 1 | Asynchronous flag: burden limit exceeded |
| hold_cycles | input | HOLD_W | Settling hold-off length, in clock cycles |
| ovr_en | input | 1 | Host override enable (synchronous to `clk`) |
| ovr_small_on | input | 1 | Host request: small-shunt switch on |
| ovr_mid_on | input | 1 | Host request: mid-shunt switch on |
| gate_small_n | output | 1 | Active-low gate drive, small-shunt switch |
| gate_mid_n | output | 1 | Active-low gate drive, mid-shunt switch |
| range_code | output | 2 | Present range code |

## Verification
The bench builds the block with `HOLD_W` = 8 and the default two-stage synchronizer, and uses a hold-off of 3 cycles. This makes it possible to watch a step that is still blocked three edges after the previous change and then lands on the fourth. It also lets an emergency be placed while the counter is still nonzero. A directed run with a hold-off of 0 shows steps on back-to-back edges. The reset value of the range is left at its default of 2.

// File: rtl/autorange_pkg.sv
package autorange_pkg;

   typedef enum logic [1:0] {
      RNG_HI_OHM  = 2'd0,
      RNG_MID_OHM = 2'd1,
      RNG_LO_OHM  = 2'd2
   } range_t;

   // returns {small_on, mid_on} for a legal range
   function automatic logic [1:0] range_to_sw(range_t r);
      logic [1:0] sw;
      case (r)
         RNG_LO_OHM:  sw = 2'b11;
         RNG_MID_OHM: sw = 2'b01;
         default:     sw = 2'b00;
      endcase
      return sw;
   endfunction

endpackage

// File: rtl/ar_sync.sv
module ar_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ar_holdoff.sv
module ar_holdoff #(
   parameter int HOLD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              clear,
   input  logic [HOLD_W-1:0] load_val,
   output logic [HOLD_W-1:0] cnt,
   output logic              busy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (clear)      cnt <= '0;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/ar_range_fsm.sv
module ar_range_fsm
   import autorange_pkg::*;
#(
   parameter int RST_RANGE = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   above_s,
   input  logic   below_s,
   input  logic   burden_s,
   input  logic   ovr_en,
   input  logic   ovr_small_on,
   input  logic   ovr_mid_on,
   input  logic   hold_busy,
   output range_t range_q,
   output logic   sw_small_q,
   output logic   sw_mid_q,
   output logic   hold_load,
   output logic   hold_clear
);
   localparam range_t RST_R = range_t'(RST_RANGE);
   localparam logic [1:0] RST_SW = range_to_sw(RST_R);

   range_t     range_d;
   logic [1:0] sw_d;

   always_comb begin
      range_d    = range_q;
      sw_d       = {sw_small_q, sw_mid_q};
      hold_load  = 1'b0;
      hold_clear = 1'b0;
      if (burden_s) begin
         range_d   = RNG_LO_OHM;
         sw_d      = 2'b11;
         hold_load = 1'b1;
      end else if (ovr_en) begin
         sw_d       = {ovr_small_on, ovr_mid_on};
         hold_clear = 1'b1;
         if (ovr_small_on)    range_d = RNG_LO_OHM;
         else if (ovr_mid_on) range_d = RNG_MID_OHM;
         else                 range_d = RNG_HI_OHM;
      end else begin
         if (!hold_busy) begin
            if (above_s) begin
               if (range_q != RNG_LO_OHM) range_d = range_t'(range_q + 2'd1);
            end else if (below_s) begin
               if (range_q != RNG_HI_OHM) range_d = range_t'(range_q - 2'd1);
            end
         end
         sw_d      = range_to_sw(range_d);
         hold_load = (range_d != range_q);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         range_q    <= RST_R;
         sw_small_q <= RST_SW[1];
         sw_mid_q   <= RST_SW[0];
      end else begin
         range_q    <= range_d;
         sw_small_q <= sw_d[1];
         sw_mid_q   <= sw_d[0];
      end
   end
endmodule

// File: rtl/shunt_autorange.sv
module shunt_autorange
   import autorange_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_W      = 16,
   parameter int RST_RANGE   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_above,
   input  logic              cmp_below,
   input  logic              cmp_burden,
   input  logic [HOLD_W-1:0] hold_cycles,
   input  logic              ovr_en,
   input  logic              ovr_small_on,
   input  logic              ovr_mid_on,
   output logic              gate_small_n,
   output logic              gate_mid_n,
   output logic [1:0]        range_code
);
   localparam int NFLAG = 3;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (HOLD_W < 1 || HOLD_W > 32) begin : g_bad_hold
      $error("HOLD_W must lie in 1..32");
   end
   if (RST_RANGE < 0 || RST_RANGE > 2) begin : g_bad_rst
      $error("RST_RANGE must lie in 0..2");
   end

   logic [NFLAG-1:0] flags_s;
   logic             above_s, below_s, burden_s;
   logic [HOLD_W-1:0] hold_cnt;
   logic             hold_busy, hold_load, hold_clear;
   logic             sw_small_q, sw_mid_q;
   range_t           range_q;

   ar_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cmp_burden, cmp_above, cmp_below}),
      .q     (flags_s)
   );
   assign {burden_s, above_s, below_s} = flags_s;

   ar_holdoff #(.HOLD_W(HOLD_W)) i_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (hold_load),
      .clear    (hold_clear),
      .load_val (hold_cycles),
      .cnt      (hold_cnt),
      .busy     (hold_busy)
   );

   ar_range_fsm #(.RST_RANGE(RST_RANGE)) i_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .above_s      (above_s),
      .below_s      (below_s),
      .burden_s     (burden_s),
      .ovr_en       (ovr_en),
      .ovr_small_on (ovr_small_on),
      .ovr_mid_on   (ovr_mid_on),
      .hold_busy    (hold_busy),
      .range_q      (range_q),
      .sw_small_q   (sw_small_q),
      .sw_mid_q     (sw_mid_q),
      .hold_load    (hold_load),
      .hold_clear   (hold_clear)
   );

   assign gate_small_n = ~sw_small_q;
   assign gate_mid_n   = ~sw_mid_q;
   assign range_code   = range_q;
endmodule

// File: rtl/ar_checker.sv
module ar_checker #(
   parameter int HOLD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ovr_en,
   input logic              above_s,
   input logic              burden_s,
   input logic              hold_busy,
   input logic [HOLD_W-1:0] hold_cnt,
   input logic [HOLD_W-1:0] hold_cycles,
   input logic [1:0]        range_code,
   input logic              gate_small_n,
   input logic              gate_mid_n
);
   AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      range_code != 2'd3); // R2

   AST_NO_SMALL_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      !ovr_en |=> !(gate_small_n == 1'b0 && gate_mid_n == 1'b1)); // R2

   AST_EMERGENCY_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
      burden_s |=> (range_code == 2'd2 && !gate_small_n && !gate_mid_n)); // R8

   AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!burden_s && !ovr_en && hold_busy) |=> $stable(range_code)); // R7

   AST_NO_SKIP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (!burden_s && !ovr_en && range_code == 2'd0) |=> range_code != 2'd2); // R4

   AST_STEP_UP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (!burden_s && !ovr_en && !hold_busy && above_s && range_code != 2'd2)
      |=> (range_code == $past(range_code) + 2'd1 && hold_cnt == $past(hold_cycles))); // R7

   AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_en && !burden_s) |=> hold_cnt == '0); // R9
endmodule

bind shunt_autorange ar_checker #(.HOLD_W(HOLD_W)) i_ar_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .ovr_en       (ovr_en),
   .above_s      (above_s),
   .burden_s     (burden_s),
   .hold_busy    (hold_busy),
   .hold_cnt     (hold_cnt),
   .hold_cycles  (hold_cycles),
   .range_code   (range_code),
   .gate_small_n (gate_small_n),
   .gate_mid_n   (gate_mid_n)
);

// File: tb/test_shunt_autorange.sv
module test_shunt_autorange;
   localparam int CLK_PERIOD = 10;
   localparam int HW = 8;
   localparam int NV = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmp_above = 1'b0, cmp_below = 1'b0, cmp_burden = 1'b0;
   logic [HW-1:0] hold_cycles = '0;
   logic          ovr_en = 1'b0, ovr_small_on = 1'b0, ovr_mid_on = 1'b0;
   logic          gate_small_n, gate_mid_n;
   logic [1:0]    range_code;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   shunt_autorange #(.SYNC_STAGES(2), .HOLD_W(HW)) i_shunt_autorange (
      .clk, .rst_n, .cmp_above, .cmp_below, .cmp_burden, .hold_cycles,
      .ovr_en, .ovr_small_on, .ovr_mid_on, .gate_small_n, .gate_mid_n,
      .range_code
   );

   // {above, below, burden, ovr, ovr_small, ovr_mid, hold[8], wait[8], range[2], gs_n, gm_n}
   localparam logic [25:0] TBL [NV] = '{
      {6'b010000, 8'd3, 8'd3, 2'd1, 2'b10},  // 0  R3 first step down
      {6'b010000, 8'd3, 8'd3, 2'd1, 2'b10},  // 1  R7 still held
      {6'b010000, 8'd3, 8'd1, 2'd0, 2'b11},  // 2  R3 step after hold
      {6'b010000, 8'd3, 8'd5, 2'd0, 2'b11},  // 3  R3 floor
      {6'b110000, 8'd3, 8'd3, 2'd1, 2'b10},  // 4  R5 above wins
      {6'b110000, 8'd3, 8'd4, 2'd2, 2'b00},  // 5  R4 step up
      {6'b100000, 8'd3, 8'd5, 2'd2, 2'b00},  // 6  R4 ceiling
      {6'b000000, 8'd3, 8'd6, 2'd2, 2'b00},  // 7  R2 idle
      {6'b010000, 8'd3, 8'd3, 2'd1, 2'b10},  // 8  R6 latency
      {6'b010000, 8'd3, 8'd4, 2'd0, 2'b11},  // 9  R3
      {6'b011000, 8'd3, 8'd2, 2'd0, 2'b11},  // 10 R6 burden in sync
      {6'b011000, 8'd3, 8'd1, 2'd2, 2'b00},  // 11 R8 jump
      {6'b011000, 8'd3, 8'd5, 2'd2, 2'b00},  // 12 R8 held
      {6'b010000, 8'd3, 8'd5, 2'd2, 2'b00},  // 13 R7 reload by burden
      {6'b010000, 8'd3, 8'd1, 2'd1, 2'b10},  // 14 R7
      {6'b000101, 8'd3, 8'd1, 2'd1, 2'b10},  // 15 R9 mid
      {6'b000110, 8'd3, 8'd1, 2'd2, 2'b01},  // 16 R9 small only
      {6'b100100, 8'd3, 8'd4, 2'd0, 2'b11},  // 17 R9 above ignored
      {6'b101100, 8'd3, 8'd3, 2'd2, 2'b00},  // 18 R10
      {6'b000000, 8'd3, 8'd6, 2'd2, 2'b00}   // 19 R2
   };

   function automatic string tag(int i);
      case (i)
         0, 2, 3, 9:      return "R3";
         1, 13, 14:       return "R7";
         4:               return "R5";
         5, 6:            return "R4";
         8, 10:           return "R6";
         11, 12:          return "R8";
         15, 16, 17:      return "R9";
         18:              return "R10";
         default:         return "R2";
      endcase
   endfunction

   task automatic chk(string req, string what, int got, int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
      end
   endtask

   task automatic chk_all(string req, int rng, int gs, int gm);
      chk(req, "range_code", int'(range_code), rng);
      chk(req, "gate_small_n", int'(gate_small_n), gs);
      chk(req, "gate_mid_n", int'(gate_mid_n), gm);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog got=%0d exp=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_all("R1", 2, 0, 0);            // in reset
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R1", 2, 0, 0);            // after release

      for (int i = 0; i < NV; i++) begin
         logic [25:0] v;
         v = TBL[i];
         {cmp_above, cmp_below, cmp_burden, ovr_en, ovr_small_on, ovr_mid_on} = v[25:20];
         hold_cycles = v[19:12];
         repeat (int'(v[11:4])) @(posedge clk);
         @(negedge clk);
         chk_all(tag(i), int'(v[3:2]), int'(v[1]), int'(v[0]));
      end

      // R7 with zero hold-off: steps on consecutive edges
      hold_cycles = 8'd0;
      cmp_below = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_all("R7", 1, 1, 0);
      @(posedge clk);
      @(negedge clk);
      chk_all("R7", 0, 1, 1);

      // R1 reset in the middle of operation
      rst_n = 1'b0;
      @(negedge clk);
      chk_all("R1", 2, 0, 0);
      cmp_below = 1'b0;
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk_all("R1", 2, 0, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule